// File: doc/BRIEF.md
# Peripheral Register Bit-Field Sequencer

This block sits beside a small control core and carries out bit-field operations on a 32-bit peripheral register bus for it. Each request names a register address, an upper bit position, a lower bit position and, for a store, an 8-bit value. A field load fetches the whole register and returns the selected bits shifted down to bit 0 in a 16-bit result. A field store reads the register, replaces only the selected bits and writes the whole word back, so every other bit keeps its value.

Every request runs on a fixed nominal schedule. The first two cycles model the fetch. After them come six execute cycles for a load or ten for a store. When the bus target holds off its ready signal, the schedule pauses for exactly those cycles. A request whose field is malformed still completes on its nominal schedule, but with an error flag raised and no bus traffic at all.

Top module: `bitfield_access_seq`

## Requirements
- R1: `req_ready` is high exactly when no request is in progress. A request is taken on a rising edge where both `req_valid` and `req_ready` are high, and `req_ready` stays low until after that request's `done` cycle. `req_write` = 1 selects a field store and 0 selects a field load.
- R2: A valid load returns bits `req_hi` down to `req_lo` of the addressed register, shifted so that bit `req_lo` lands on `done_rdata[0]`. All result bits above the field width are zero.
- R3: A valid store leaves bits `req_hi` down to `req_lo` of the addressed register equal to the low (hi-lo+1) bits of `req_data`, and leaves every bit outside that range unchanged. It does this with one bus read followed by one bus write to the same address.
- R4: With `bus_ready` held high, a load's `done` pulse appears in the 8th cycle after the accepting edge (2 fetch cycles plus 6 execute cycles).
- R5: With `bus_ready` held high, a store's `done` pulse appears in the 12th cycle after the accepting edge (2 fetch cycles plus 10 execute cycles).
- R6: Each cycle in which `bus_req` is high while `bus_ready` is low delays `done` by exactly one cycle. During such a stall `bus_addr`, `bus_we` and `bus_wdata` hold their values.
- R7: If `req_hi` < `req_lo`, or the field is wider than 16 bits for a load or 8 bits for a store, the request completes at its nominal R4/R5 latency with `done_err` = 1 and `done_rdata` = 0. It never raises `bus_req`.
- R8: After reset `req_ready` = 1, `done` = 0 and `bus_req` = 0. `done` is a single-cycle pulse, and `done_err` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = field store, 0 = field load |
| req_addr | input | ADDR_W | Register address |
| req_hi | input | POS_W | Upper bit of the field |
| req_lo | input | POS_W | Lower bit of the field |
| req_data | input | 8 | Value for a field store |
| done | output | 1 | Request complete (one cycle) |
| done_err | output | 1 | Request rejected as malformed |
| done_rdata | output | RES_W | Right-aligned field from a load |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write word |
| bus_rdata | input | DATA_W | Bus read word |
| bus_ready | input | 1 | Bus access completes this cycle |

## Verification
A corrupted step counter shows up at once as a `done` pulse in the wrong cycle, or as a bus access at the wrong point in the schedule. A counter that keeps running through a stall shortens the measured latency by the stall length. A stale or wrong mask register shows up on the next store as a changed bit outside the field in the register contents, or on the next load as nonzero bits above the field in the result. Both are visible as soon as that request completes. A validity flag that is latched wrongly shows up as bus traffic during an error request, or as a missing `done_err` in the nominal completion cycle.

// File: rtl/bfa_pkg.sv
package bfa_pkg;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } bfa_op_e;

    typedef struct packed {
        bfa_op_e op;
        logic    bad;
    } bfa_ctl_t;

    localparam int BFA_STORE_W = 8;

endpackage

// File: rtl/bfa_field_decode.sv
module bfa_field_decode
    import bfa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int POS_W  = 5,
    parameter int RD_MAX = 16,
    parameter int WR_MAX = 8
) (
    input  logic [POS_W-1:0]  hi,
    input  logic [POS_W-1:0]  lo,
    input  bfa_op_e           op,
    output logic [DATA_W-1:0] mask,
    output bfa_ctl_t          ctl
);
    logic [POS_W:0]  width;
    logic [DATA_W:0] ones;
    logic            too_wide;

    always_comb begin
        width    = {1'b0, hi} - {1'b0, lo} + 1'b1;
        too_wide = (op == OP_STORE) ? (int'(width) > WR_MAX) : (int'(width) > RD_MAX);
        ones     = ({{DATA_W{1'b0}}, 1'b1} << width) - 1'b1;
        mask     = ones[DATA_W-1:0] << lo;
        ctl.op   = op;
        ctl.bad  = (hi < lo) || too_wide;
    end
endmodule

// File: rtl/bfa_step_timer.sv
module bfa_step_timer
    import bfa_pkg::*;
#(
    parameter int FETCH_CYC = 2,
    parameter int RD_EXEC   = 6,
    parameter int WR_EXEC   = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  bfa_ctl_t ctl_in,
    input  logic     bus_ready,
    output logic     busy,
    output bfa_ctl_t ctl_q,
    output logic     rd_step,
    output logic     mg_step,
    output logic     wr_step,
    output logic     last
);
    localparam int RD_LAST = FETCH_CYC + RD_EXEC - 1;
    localparam int WR_LAST = FETCH_CYC + WR_EXEC - 1;
    localparam int CNT_W   = $clog2(FETCH_CYC + RD_EXEC + WR_EXEC + 1);

    logic [CNT_W-1:0] tick;
    logic             hold;
    logic             is_st;

    always_comb begin
        is_st   = (ctl_q.op == OP_STORE);
        rd_step = busy && !ctl_q.bad && (tick == CNT_W'(FETCH_CYC));
        mg_step = busy && !ctl_q.bad && is_st && (tick == CNT_W'(FETCH_CYC + 1));
        wr_step = busy && !ctl_q.bad && is_st && (tick == CNT_W'(FETCH_CYC + 2));
        hold    = (rd_step || wr_step) && !bus_ready;
        last    = busy && (tick == (is_st ? CNT_W'(WR_LAST) : CNT_W'(RD_LAST)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            tick  <= '0;
            ctl_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            tick  <= '0;
            ctl_q <= ctl_in;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
            end else if (!hold) begin
                tick <= tick + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bfa_datapath.sv
module bfa_datapath
    import bfa_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int POS_W  = 5,
    parameter int RES_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [POS_W-1:0]  req_lo,
    input  logic [BFA_STORE_W-1:0] req_data,
    input  logic [DATA_W-1:0] mask_in,
    input  bfa_ctl_t          ctl_q,
    input  logic              rd_step,
    input  logic              mg_step,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] merged_q,
    output logic [RES_W-1:0]  result_q
);
    logic [POS_W-1:0]       lo_q;
    logic [BFA_STORE_W-1:0] data_q;
    logic [DATA_W-1:0]      mask_q;
    logic [DATA_W-1:0]      word_q;
    logic [DATA_W-1:0]      extracted;
    logic [DATA_W-1:0]      placed;

    always_comb begin
        extracted = (bus_rdata & mask_q) >> lo_q;
        placed    = {{(DATA_W-BFA_STORE_W){1'b0}}, data_q} << lo_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            lo_q     <= '0;
            data_q   <= '0;
            mask_q   <= '0;
            word_q   <= '0;
            merged_q <= '0;
            result_q <= '0;
        end else begin
            if (start) begin
                addr_q   <= req_addr;
                lo_q     <= req_lo;
                data_q   <= req_data;
                mask_q   <= mask_in;
                result_q <= '0;
            end
            if (rd_step && bus_ready) begin
                word_q <= bus_rdata;
                if (ctl_q.op == OP_LOAD) begin
                    result_q <= extracted[RES_W-1:0];
                end
            end
            if (mg_step) begin
                merged_q <= (word_q & ~mask_q) | (placed & mask_q);
            end
        end
    end
endmodule

// File: rtl/bitfield_access_seq.sv
module bitfield_access_seq
    import bfa_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int RES_W     = 16,
    parameter int FETCH_CYC = 2,
    parameter int RD_EXEC   = 6,
    parameter int WR_EXEC   = 10,
    localparam int POS_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [POS_W-1:0]  req_hi,
    input  logic [POS_W-1:0]  req_lo,
    input  logic [7:0]        req_data,
    output logic              done,
    output logic              done_err,
    output logic [RES_W-1:0]  done_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready
);
    logic              start;
    logic              busy;
    logic              rd_step;
    logic              mg_step;
    logic              wr_step;
    logic              last;
    logic [DATA_W-1:0] mask_in;
    bfa_ctl_t          ctl_in;
    bfa_ctl_t          ctl_q;
    bfa_op_e           op_in;

    assign op_in     = req_write ? OP_STORE : OP_LOAD;
    assign req_ready = !busy;
    assign start     = req_valid && req_ready;

    bfa_field_decode #(
        .DATA_W (DATA_W),
        .POS_W  (POS_W),
        .RD_MAX (RES_W),
        .WR_MAX (BFA_STORE_W)
    ) u_decode (
        .hi   (req_hi),
        .lo   (req_lo),
        .op   (op_in),
        .mask (mask_in),
        .ctl  (ctl_in)
    );

    bfa_step_timer #(
        .FETCH_CYC (FETCH_CYC),
        .RD_EXEC   (RD_EXEC),
        .WR_EXEC   (WR_EXEC)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ctl_in    (ctl_in),
        .bus_ready (bus_ready),
        .busy      (busy),
        .ctl_q     (ctl_q),
        .rd_step   (rd_step),
        .mg_step   (mg_step),
        .wr_step   (wr_step),
        .last      (last)
    );

    bfa_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .POS_W  (POS_W),
        .RES_W  (RES_W)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_addr  (req_addr),
        .req_lo    (req_lo),
        .req_data  (req_data),
        .mask_in   (mask_in),
        .ctl_q     (ctl_q),
        .rd_step   (rd_step),
        .mg_step   (mg_step),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .addr_q    (bus_addr),
        .merged_q  (bus_wdata),
        .result_q  (done_rdata)
    );

    assign bus_req  = rd_step || wr_step;
    assign bus_we   = wr_step;
    assign done     = last;
    assign done_err = last && ctl_q.bad;
endmodule

// File: rtl/bfa_checker.sv
module bfa_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int RES_W  = 16,
    parameter int POS_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [POS_W-1:0]  req_hi,
    input logic [POS_W-1:0]  req_lo,
    input logic              done,
    input logic              done_err,
    input logic [RES_W-1:0]  done_rdata,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_ready
);
    logic              c_bad;
    logic [DATA_W-1:0] c_keep;
    logic [DATA_W-1:0] c_word;
    int                c_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_bad  <= 1'b0;
            c_keep <= '1;
            c_word <= '0;
            c_w    <= 0;
        end else begin
            if (req_valid && req_ready) begin
                c_w    <= int'(req_hi) - int'(req_lo) + 1;
                c_bad  <= (req_hi < req_lo) ||
                          ((int'(req_hi) - int'(req_lo) + 1) > (req_write ? 8 : RES_W));
                for (int i = 0; i < DATA_W; i++) begin
                    c_keep[i] <= !((i >= int'(req_lo)) && (i <= int'(req_hi)));
                end
            end
            if (bus_req && !bus_we && bus_ready) begin
                c_word <= bus_rdata;
            end
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R1
    AST_BUS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !req_ready); // R1
    AST_ZERO_ABOVE_FIELD: assert property (@(posedge clk) disable iff (rst)
        (done && !done_err) |-> ((32'(done_rdata) >> c_w) == 32'd0)); // R2
    AST_KEEP_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |-> (((bus_wdata ^ c_word) & c_keep) == '0)); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))); // R6
    AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !c_bad); // R7
    AST_ERR_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
        done_err |-> (done_rdata == '0)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        done_err |-> done); // R8
endmodule

bind bitfield_access_seq bfa_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .RES_W  (RES_W),
    .POS_W  (POS_W)
) u_bfa_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_hi     (req_hi),
    .req_lo     (req_lo),
    .done       (done),
    .done_err   (done_err),
    .done_rdata (done_rdata),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_ready  (bus_ready)
);

// File: tb/bitfield_access_seq_bench.sv
module bitfield_access_seq_bench;
    localparam int AW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [4:0]  req_hi = '0;
    logic [4:0]  req_lo = '0;
    logic [7:0]  req_data = '0;
    logic        done;
    logic        done_err;
    logic [15:0] done_rdata;
    logic        bus_req;
    logic        bus_we;
    logic [AW-1:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ready = 1'b1;

    logic [31:0] mem   [16];
    logic [31:0] model [16];
    int n_cmp = 0;
    int n_bad = 0;
    int stall_set = 0;
    int stall_cnt = 0;
    int xfers = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    bitfield_access_seq #(.ADDR_W(AW)) u_bitfield_access_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_hi(req_hi), .req_lo(req_lo),
        .req_data(req_data), .done(done), .done_err(done_err), .done_rdata(done_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    assign bus_rdata = mem[bus_addr];

    always @(posedge clk) begin
        cycles++;
        if (bus_req && bus_ready) begin
            xfers++;
            if (bus_we) mem[bus_addr] <= bus_wdata;
        end
    end

    always @(negedge clk) begin
        if (bus_req) begin
            if (stall_cnt < stall_set) begin
                bus_ready = 1'b0;
                stall_cnt++;
            end else begin
                bus_ready = 1'b1;
            end
        end else begin
            bus_ready = 1'b1;
            stall_cnt = 0;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_req(input bit wr, input int addr, input int hi, input int lo,
                           input int data, input int stall);
        int     n;
        int     x0;
        int     w;
        bit     bad;
        int     lat;
        longint fmask;
        longint exp_rd;
        longint old;
        w     = hi - lo + 1;
        bad   = (hi < lo) || (w > (wr ? 8 : 16));
        old   = longint'(model[addr]);
        fmask = bad ? 0 : (((64'd1 << w) - 1) << lo);
        exp_rd = bad ? 0 : ((old & fmask) >> lo);
        lat   = (wr ? 12 : 8) + (bad ? 0 : stall * (wr ? 2 : 1));
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        stall_set = stall;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(addr);
        req_hi    = 5'(hi);
        req_lo    = 5'(lo);
        req_data  = 8'(data);
        @(posedge clk);
        x0 = xfers;
        n  = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (n == 1) req_valid = 1'b0;
            if (done || n > 200) break;
        end
        if (wr) check(n == lat, "R5 store latency", n, lat);
        else    check(n == lat, "R4 load latency", n, lat);
        if (stall > 0 && !bad) check(n == lat, "R6 stall extension", n, lat);
        check(done_err == bad, "R7 error flag", done_err, bad);
        if (bad) begin
            check(xfers == x0, "R7 no bus traffic", xfers - x0, 0);
            check(done_rdata == 0, "R7 zero result", done_rdata, 0);
        end else if (!wr) begin
            check(longint'(done_rdata) == exp_rd, "R2 load field", done_rdata, exp_rd);
        end else begin
            model[addr] = 32'((old & ~fmask) | ((longint'(data) << lo) & fmask));
        end
        @(negedge clk);
        check(!done, "R8 done single pulse", done, 0);
        check(req_ready, "R1 ready after done", req_ready, 1);
        if (wr) begin
            check(mem[addr] == model[addr], "R3 store merge", mem[addr], model[addr]);
            if (!bad) check(xfers - x0 == 2, "R3 read then write", xfers - x0, 2);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i]   = 32'h9E3779B9 * (i + 1) ^ 32'h5A5A0F0F;
            model[i] = 32'h9E3779B9 * (i + 1) ^ 32'h5A5A0F0F;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R8 reset ready", req_ready, 1);
        check(done == 1'b0, "R8 reset done", done, 0);
        check(bus_req == 1'b0, "R8 reset bus_req", bus_req, 0);
        // R1 back-to-back handling via run_req wait on ready
        for (int lo = 0; lo < 32; lo++) begin
            for (int w = 1; w <= 18 && lo + w - 1 < 32; w++) begin
                run_req(1'b0, (lo + w) % 16, lo + w - 1, lo, 0, (lo + w) % 3);
            end
        end
        for (int lo = 0; lo < 32; lo++) begin
            for (int w = 1; w <= 10 && lo + w - 1 < 32; w++) begin
                run_req(1'b1, (lo * 3 + w) % 16, lo + w - 1, lo, lo * 29 + w * 11 + 5, (lo + 2 * w) % 3);
            end
        end
        for (int lo = 1; lo < 32; lo += 3) begin
            run_req(1'b0, lo % 16, lo - 1, lo, 0, 1);
            run_req(1'b1, lo % 16, lo - 1, lo, 8'hFF, 1);
        end
        for (int a = 0; a < 16; a++) begin
            run_req(1'b0, a, 15, 0, 0, 0);
            run_req(1'b0, a, 31, 16, 0, 2);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        while (cycles < 150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule